// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a parallel NOR flash interface. Every write arrives as a chip-enable and write-enable strobe pair. The block brings both strobes into its clock domain, forms one write cycle from each pair, and walks the flash command state machine: it tracks the two-cycle unlock prefix, the longer erase prefix and an unlock-bypass mode in which program sequences are shorter.

When a sequence completes, the block emits a single-cycle operation pulse. The pulse carries an operation code, the address and data of the final cycle, and the bank field taken from the top address bits. Sequences that go wrong are dropped silently.

Execution is left to the downstream engine: it runs the embedded program and erase algorithms and tells this block, through a busy flag, when an erase is in progress. The array, status polling and read paths are not part of this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `op_valid_o` is 0 and `bypass_o` is 0.
- R2: The address of a write cycle is captured when both strobes are first low together. The data is captured when the first of the two strobes returns high. Each strobe pair yields exactly one write cycle, whichever strobe leads.
- R3: Unlock and command cycles compare only address bits [11:0] (0xAAA, 0x555 or 0x0AA) and data bits [7:0]. Address bits above bit 11 do not affect the match.
- R4: The cycles AA@AAA, 55@555, A0@AAA and then any data at any address give one pulse with code 1. That pulse carries the final address and the full data word, and the data word may be 0xF0.
- R5: AA@AAA, 55@555, 80@AAA, AA@AAA, 55@555 and then 10@AAA give code 2 (chip erase). The same five-cycle prefix followed by 30 at any address gives code 3 (sector erase), carrying that address.
- R6: A write of F0 to any address gives code 6 and clears any partial sequence. The exception is the data cycle of a program, where F0 is treated as data.
- R7: AA@AAA, 55@555 and then 20@AAA give code 9 and set `bypass_o`. While in bypass, A0 at any address followed by a data write gives code 11, carrying that cycle's address and data.
- R8: In bypass, 90 followed by 00 (any addresses) gives code 10 and clears `bypass_o`.
- R9: In either mode, from an idle state, B0 gives code 4 (suspend) and 30 gives code 5 (resume), but only while `erase_busy_i` is 1. Otherwise these writes produce no pulse.
- R10: AA@AAA, 55@555 and then 90@AAA give code 7 (autoselect). From idle in normal mode, 98 at low address 0x0AA gives code 8 (CFI query). Every pulse sets `op_bank_o` to `op_addr_o[AW-1 -: BANK_W]`.
- R11: A cycle that does not fit the expected next step drops the sequence without a pulse and returns to idle. The bypass mode is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable strobe, active low |
| we_ni | input | 1 | Write enable strobe, active low |
| addr_i | input | AW | Flash word address |
| data_i | input | DW | Write data |
| erase_busy_i | input | 1 | An erase is in progress (from the algorithm engine) |
| op_valid_o | output | 1 | One-cycle operation pulse |
| op_code_o | output | 4 | Operation code (see R4 to R10) |
| op_addr_o | output | AW | Address of the final cycle |
| op_data_o | output | DW | Data of the final cycle |
| op_bank_o | output | BANK_W | Bank field of `op_addr_o` |
| bypass_o | output | 1 | Unlock-bypass mode active |

## Verification
The bench uses the default parameters: AW=20, DW=16, CMP_W=12, BANK_W=2 and SYNC_STAGES=2. With these values the unlock cycles can carry non-zero bits in the eight address bits above the compare field, so R3 is tested directly. The four bank values can be reached through the top two bits. Both strobe orders are driven, and the address and data buses are changed while the strobes are held low or high. This shows that each field is taken on its own edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [3:0] {
    OP_NONE       = 4'd0,
    OP_PROG       = 4'd1,
    OP_CHIP_ERASE = 4'd2,
    OP_SECT_ERASE = 4'd3,
    OP_SUSPEND    = 4'd4,
    OP_RESUME     = 4'd5,
    OP_RESET      = 4'd6,
    OP_AUTOSEL    = 4'd7,
    OP_CFI        = 4'd8,
    OP_BYP_ENTER  = 4'd9,
    OP_BYP_EXIT   = 4'd10,
    OP_BYP_PROG   = 4'd11
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_ERS1,
    ST_ERSU1, ST_ERSU2, ST_BPROG, ST_BRST
  } st_e;

  localparam logic [11:0] LO_UNL1 = 12'hAAA;
  localparam logic [11:0] LO_UNL2 = 12'h555;
  localparam logic [11:0] LO_CFI  = 12'h0AA;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  output logic act_o
);
  logic [STAGES-1:0] ce_sr, we_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_sr <= '1;
      we_sr <= '1;
    end else begin
      ce_sr <= {ce_sr[STAGES-2:0], ce_ni};
      we_sr <= {we_sr[STAGES-2:0], we_ni};
    end
  end

  assign act_o = ~ce_sr[STAGES-1] & ~we_sr[STAGES-1];
endmodule

// File: rtl/cycle_capture.sv
module cycle_capture #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          cyc_v_o,
  output logic [AW-1:0] cyc_addr_o,
  output logic [DW-1:0] cyc_data_o
);
  logic act_q;
  logic act_rise, act_fall;

  assign act_rise = act_i & ~act_q;  // later of the two falling strobes
  assign act_fall = ~act_i & act_q;  // earlier of the two rising strobes

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      cyc_v_o    <= 1'b0;
      cyc_addr_o <= '0;
      cyc_data_o <= '0;
    end else begin
      act_q   <= act_i;
      cyc_v_o <= act_fall;
      if (act_rise) cyc_addr_o <= addr_i;
      if (act_fall) cyc_data_o <= data_i;
    end
  end

  // R2
  one_cycle_per_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_v_o |=> !cyc_v_o);
  // R2
  addr_held_while_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && act_i) |=> $stable(cyc_addr_o));
endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int CMP_W  = 12,
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_v_i,
  input  logic [AW-1:0]     cyc_addr_i,
  input  logic [DW-1:0]     cyc_data_i,
  input  logic              erase_busy_i,
  output logic              op_valid_o,
  output logic [3:0]        op_code_o,
  output logic [AW-1:0]     op_addr_o,
  output logic [DW-1:0]     op_data_o,
  output logic [BANK_W-1:0] op_bank_o,
  output logic              bypass_o
);
  st_e  st_q, st_d;
  logic byp_q, byp_d;
  logic emit;
  op_e  code;

  logic [CMP_W-1:0] lo;
  logic [7:0]       cmd;
  logic             at_u1, at_u2, is_u1, is_u2, is_f0, busy_ok;

  assign lo      = cyc_addr_i[CMP_W-1:0];
  assign cmd     = cyc_data_i[7:0];
  assign at_u1   = lo == CMP_W'(LO_UNL1);
  assign at_u2   = lo == CMP_W'(LO_UNL2);
  assign is_u1   = at_u1 && cmd == 8'hAA;
  assign is_u2   = at_u2 && cmd == 8'h55;
  assign is_f0   = cmd == 8'hF0;
  assign busy_ok = erase_busy_i;

  always_comb begin
    st_d  = st_q;
    byp_d = byp_q;
    emit  = 1'b0;
    code  = OP_NONE;
    if (cyc_v_i) begin
      st_d = ST_IDLE;
      if (is_f0 && st_q != ST_PROG && st_q != ST_BPROG) begin
        emit = 1'b1;
        code = OP_RESET;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            if (!byp_q && is_u1) st_d = ST_UNL1;
            else if (!byp_q && cmd == 8'h98 && lo == CMP_W'(LO_CFI)) begin
              emit = 1'b1; code = OP_CFI;
            end
            else if (byp_q && cmd == 8'hA0) st_d = ST_BPROG;
            else if (byp_q && cmd == 8'h90) st_d = ST_BRST;
            else if (cmd == 8'hB0 && busy_ok) begin
              emit = 1'b1; code = OP_SUSPEND;
            end
            else if (cmd == 8'h30 && busy_ok) begin
              emit = 1'b1; code = OP_RESUME;
            end
          end
          ST_UNL1: if (is_u2) st_d = ST_UNL2;
          ST_UNL2: begin
            if (at_u1) begin
              unique case (cmd)
                8'hA0: st_d = ST_PROG;
                8'h80: st_d = ST_ERS1;
                8'h20: begin emit = 1'b1; code = OP_BYP_ENTER; byp_d = 1'b1; end
                8'h90: begin emit = 1'b1; code = OP_AUTOSEL; end
                default: ;
              endcase
            end
          end
          ST_PROG:  begin emit = 1'b1; code = OP_PROG; end
          ST_ERS1:  if (is_u1) st_d = ST_ERSU1;
          ST_ERSU1: if (is_u2) st_d = ST_ERSU2;
          ST_ERSU2: begin
            if (at_u1 && cmd == 8'h10) begin emit = 1'b1; code = OP_CHIP_ERASE; end
            else if (cmd == 8'h30) begin emit = 1'b1; code = OP_SECT_ERASE; end
          end
          ST_BPROG: begin emit = 1'b1; code = OP_BYP_PROG; end
          ST_BRST: begin
            if (cmd == 8'h00) begin emit = 1'b1; code = OP_BYP_EXIT; byp_d = 1'b0; end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      byp_q      <= 1'b0;
      op_valid_o <= 1'b0;
      op_code_o  <= OP_NONE;
      op_addr_o  <= '0;
      op_data_o  <= '0;
      op_bank_o  <= '0;
    end else begin
      st_q       <= st_d;
      byp_q      <= byp_d;
      op_valid_o <= emit;
      if (emit) begin
        op_code_o <= code;
        op_addr_o <= cyc_addr_i;
        op_data_o <= cyc_data_i;
        op_bank_o <= cyc_addr_i[AW-1 -: BANK_W];
      end
    end
  end

  assign bypass_o = byp_q;

  // R7
  bypass_enter_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byp_q) |-> (op_valid_o && op_code_o == OP_BYP_ENTER));
  // R8
  bypass_exit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(byp_q) |-> (op_valid_o && op_code_o == OP_BYP_EXIT));
  // R9
  suspend_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && (op_code_o == OP_SUSPEND || op_code_o == OP_RESUME)) |-> $past(erase_busy_i));
  // R11
  op_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |=> !op_valid_o);
  // R11
  op_follows_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> $past(cyc_v_i));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int CMP_W       = 12,
  parameter int BANK_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic              erase_busy_i,
  output logic              op_valid_o,
  output logic [3:0]        op_code_o,
  output logic [AW-1:0]     op_addr_o,
  output logic [DW-1:0]     op_data_o,
  output logic [BANK_W-1:0] op_bank_o,
  output logic              bypass_o
);
  logic          act;
  logic          cyc_v;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_data;

  strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .act_o(act)
  );

  cycle_capture #(.AW(AW), .DW(DW)) i_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .addr_i(addr_i), .data_i(data_i),
    .cyc_v_o(cyc_v), .cyc_addr_o(cyc_addr), .cyc_data_o(cyc_data)
  );

  cmd_fsm #(.AW(AW), .DW(DW), .CMP_W(CMP_W), .BANK_W(BANK_W)) i_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_v_i(cyc_v), .cyc_addr_i(cyc_addr),
    .cyc_data_i(cyc_data), .erase_busy_i(erase_busy_i),
    .op_valid_o(op_valid_o), .op_code_o(op_code_o), .op_addr_o(op_addr_o),
    .op_data_o(op_data_o), .op_bank_o(op_bank_o), .bypass_o(bypass_o)
  );
endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1;
  logic [19:0] addr = '0;
  logic [15:0] data = '0;
  logic        busy = 1'b0;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [19:0] op_addr;
  logic [15:0] op_data;
  logic [1:0]  op_bank;
  logic        bypass;

  always #10 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .addr_i(addr),
    .data_i(data), .erase_busy_i(busy), .op_valid_o(op_valid), .op_code_o(op_code),
    .op_addr_o(op_addr), .op_data_o(op_data), .op_bank_o(op_bank), .bypass_o(bypass)
  );

  typedef struct packed {
    logic [3:0]  code;
    logic [19:0] addr;
    logic [15:0] data;
    logic [1:0]  bank;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  int n_cmp = 0, n_bad = 0, n_push = 0, n_seen = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic expect_op(input logic [3:0] code, input logic [19:0] a,
                           input logic [15:0] d, input string req);
    exp_q.push_back({code, a, d, a[19:18]});
    req_q.push_back(req);
    n_push++;
  endtask

  // one write cycle; ce_first selects which strobe falls first and rises last
  task automatic wr(input logic [19:0] a, input logic [15:0] d, input bit ce_first = 1'b1);
    @(negedge clk);
    addr = a; data = 16'hDEAD;
    if (ce_first) begin ce_n = 1'b0; repeat (3) @(negedge clk); we_n = 1'b0; end
    else begin we_n = 1'b0; repeat (3) @(negedge clk); ce_n = 1'b0; end
    repeat (6) @(negedge clk);
    addr = ~a; data = d;
    repeat (6) @(negedge clk);
    if (ce_first) begin we_n = 1'b1; repeat (3) @(negedge clk); ce_n = 1'b1; end
    else begin ce_n = 1'b1; repeat (3) @(negedge clk); we_n = 1'b1; end
    repeat (6) @(negedge clk);
    data = ~d;
    repeat (4) @(negedge clk);
  endtask

  task automatic unlock(input logic [19:0] hi = 20'h0);
    wr(hi | 20'h00AAA, 16'h00AA);
    wr(hi | 20'h00555, 16'h0055);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && op_valid) begin
      n_seen++;
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11 unexpected op actual=%h expected=none", op_code);
      end else begin
        automatic exp_t  e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        chk({op_code, op_addr, op_data, op_bank} == e, r, "op",
            64'({op_code, op_addr, op_data, op_bank}), 64'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(op_valid == 1'b0, "R1", "op_valid in reset", 64'(op_valid), 0);
    chk(bypass == 1'b0, "R1", "bypass in reset", 64'(bypass), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(op_valid == 1'b0, "R1", "op_valid after reset", 64'(op_valid), 0);

    // R3 R4 R2: upper bits set on unlock cycles, CE leads
    wr(20'h31AAA, 16'h00AA); wr(20'hC0555, 16'h0055); wr(20'h7FAAA, 16'h00A0);
    expect_op(4'd1, 20'hABCDE, 16'h1234, "R4");
    wr(20'hABCDE, 16'h1234);
    // R2: WE leads
    wr(20'h00AAA, 16'h00AA, 1'b0); wr(20'h00555, 16'h0055, 1'b0); wr(20'h00AAA, 16'h00A0, 1'b0);
    expect_op(4'd1, 20'h4F00F, 16'hBEEF, "R2");
    wr(20'h4F00F, 16'hBEEF, 1'b0);
    // R4 / R6: F0 as program data
    unlock(); wr(20'h00AAA, 16'h00A0);
    expect_op(4'd1, 20'h80123, 16'h00F0, "R6");
    wr(20'h80123, 16'h00F0);

    // R5
    unlock(); wr(20'h00AAA, 16'h0080); unlock();
    expect_op(4'd2, 20'h40AAA, 16'h0010, "R5");
    wr(20'h40AAA, 16'h0010);
    unlock(); wr(20'h00AAA, 16'h0080); unlock();
    expect_op(4'd3, 20'hC3800, 16'h0030, "R5");
    wr(20'hC3800, 16'h0030);

    // R6: F0 clears partial sequence; R11 leftovers produce nothing
    wr(20'h00AAA, 16'h00AA);
    expect_op(4'd6, 20'h12345, 16'h00F0, "R6");
    wr(20'h12345, 16'h00F0);
    wr(20'h00555, 16'h0055); wr(20'h00AAA, 16'h00A0); wr(20'h00000, 16'h1234);
    chk(n_seen == n_push, "R6", "ops after reset cmd", 64'(n_seen), 64'(n_push));

    // R11: wrong second unlock
    wr(20'h00AAA, 16'h00AA); wr(20'h00555, 16'h0056); wr(20'h00AAA, 16'h00A0);
    wr(20'h00010, 16'h7777);
    chk(n_seen == n_push, "R11", "abort emits nothing", 64'(n_seen), 64'(n_push));

    // R9
    wr(20'h40000, 16'h00B0); wr(20'h40000, 16'h0030);
    chk(n_seen == n_push, "R9", "suspend ignored when idle", 64'(n_seen), 64'(n_push));
    busy = 1'b1;
    expect_op(4'd4, 20'h40000, 16'h00B0, "R9");
    wr(20'h40000, 16'h00B0);
    expect_op(4'd5, 20'hC0000, 16'h0030, "R9");
    wr(20'hC0000, 16'h0030);
    busy = 1'b0;

    // R10
    unlock(20'h80000);
    expect_op(4'd7, 20'hC0AAA, 16'h0090, "R10");
    wr(20'hC0AAA, 16'h0090);
    expect_op(4'd8, 20'h400AA, 16'h0098, "R10");
    wr(20'h400AA, 16'h0098);

    // R7
    unlock();
    expect_op(4'd9, 20'h00AAA, 16'h0020, "R7");
    wr(20'h00AAA, 16'h0020);
    chk(bypass == 1'b1, "R7", "bypass set", 64'(bypass), 1);
    wr(20'h33333, 16'h00A0);
    expect_op(4'd11, 20'h12345, 16'h5678, "R7");
    wr(20'h12345, 16'h5678);
    // R11 in bypass: stray write, mode kept
    wr(20'h00555, 16'h0055);
    chk(n_seen == n_push && bypass == 1'b1, "R11", "bypass kept on stray",
        64'({bypass, 8'(n_seen)}), 64'({1'b1, 8'(n_push)}));
    expect_op(4'd6, 20'h00000, 16'h00F0, "R6");
    wr(20'h00000, 16'h00F0);
    chk(bypass == 1'b1, "R6", "bypass kept on F0", 64'(bypass), 1);
    // R8
    wr(20'h00001, 16'h0090);
    expect_op(4'd10, 20'hFFFFF, 16'h0000, "R8");
    wr(20'hFFFFF, 16'h0000);
    chk(bypass == 1'b0, "R8", "bypass cleared", 64'(bypass), 0);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R11", "pending expected ops", 64'(exp_q.size()), 0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule